// File: doc/BRIEF.md
# 2B1Q Transmit Line Framer

This block assembles the transmit symbol stream of a 2B1Q subscriber line. A scrambled payload bit stream comes in over a ready/valid handshake. The block packs the bits in pairs into four-level quats and places a nine-quat sync word at the head of every 120-quat frame. Each symbol is produced on a symbol strobe from the line timing, so one strobe sends one quat toward the pulse shaper.

Frames are grouped eight to a multiframe. On the frame that opens a multiframe, every quat of the sync word is sent with its polarity negated. Along with each quat, the block raises frame-start and multiframe-start flags. It also drives a square wave with a 12 ms period whose rising edge marks the multiframe start. When alignment is enabled, an external 12 ms pulse is synchronized and edge-detected, and it forces the next symbol to be the first quat of a multiframe.

Top module: `q2b1q_framer`

## Requirements
- R1: Each payload quat is built from two input bits, the earlier bit first. The pair (earlier, later) gives the level: 10 is +3, 11 is +1, 01 is -1, 00 is -3. The 2-bit output code equals that pair. The sign output is 1 for a negative level, and the magnitude output is 1 for a level of 3.
- R2: `bit_ready_o` is high exactly when fewer than two payload bits are held. A bit is taken on a clock edge where ready and valid are both high. A frame with no underrun takes 222 bits.
- R3: A frame is 120 quats. `frame_start_o` is high together with quat 0 of every frame and low on every other symbol.
- R4: Quats 0 to 8 of every frame are the sync word +3 +3 -3 -3 -3 +3 -3 +3 +3, sent in that order. The sync word never consumes payload bits.
- R5: In frame 0 of each eight-frame multiframe, every sync quat is negated. `mframe_start_o` is high together with quat 0 of frame 0 and low on every other symbol.
- R6: `mframe_sq_o` is high while frames 0 to 3 are being sent and low during frames 4 to 7. Its rising edge appears in the cycle that carries the multiframe-start quat.
- R7: With `align_mode_i` high, a rising edge on `align_i` is registered through two synchronizer flops. The first symbol strobe that arrives two or more clock cycles after the edge is applied sends quat 0 of frame 0, and counting continues from there.
- R8: With `align_mode_i` low, `align_i` has no effect on the symbol sequence.
- R9: If a payload position is strobed while fewer than two bits are held, the block sends -3 (code 00) and consumes no bits.
- R10: After reset, `quat_valid_o`, `frame_start_o`, `mframe_start_o` and `mframe_sq_o` are low and `bit_ready_o` is high. The first strobed symbol is quat 0 of frame 0.
- R11: `quat_valid_o` pulses for one cycle on the clock edge that follows each strobed cycle. The code and flags change only with that pulse, and both start flags are low whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_stb_i | input | 1 | Symbol strobe, one quat per strobed cycle |
| bit_i | input | 1 | Payload bit |
| bit_valid_i | input | 1 | Payload bit valid |
| bit_ready_o | output | 1 | Payload bit ready |
| align_mode_i | input | 1 | 1: external alignment pulse is used |
| align_i | input | 1 | External multiframe alignment pulse, asynchronous |
| quat_valid_o | output | 1 | New quat on the outputs |
| quat_code_o | output | 2 | Quat code (10 +3, 11 +1, 01 -1, 00 -3) |
| quat_neg_o | output | 1 | Quat level is negative |
| quat_big_o | output | 1 | Quat magnitude is 3 |
| frame_start_o | output | 1 | Quat is the first of a frame |
| mframe_start_o | output | 1 | Quat is the first of a multiframe |
| mframe_sq_o | output | 1 | Multiframe square wave |

## Verification
The collision that matters is an alignment edge that becomes visible in the same cycle as a symbol strobe. In that case the restart has to act on that very strobe, and it must not wait for the next one. The bench drives the pulse so that the strobe lands exactly on the first cycle the synchronized edge is seen. It also drives one case where the strobe comes a cycle too early, which must not restart. A reference model counts cycles since the pulse and predicts the position, sync polarity and flags that follow. Random valid gaps make bit acceptance meet payload consumption and underrun at the same edges.

// File: rtl/q2b1q_pkg.sv
package q2b1q_pkg;
  typedef logic [1:0] quat_code_t;

  localparam quat_code_t QC_POS3 = 2'b10;
  localparam quat_code_t QC_POS1 = 2'b11;
  localparam quat_code_t QC_NEG1 = 2'b01;
  localparam quat_code_t QC_NEG3 = 2'b00;

  // negating a level flips the top code bit
  function automatic quat_code_t quat_negate(input quat_code_t c);
    return {~c[1], c[0]};
  endfunction

  function automatic logic quat_is_neg(input quat_code_t c);
    return ~c[1];
  endfunction

  function automatic logic quat_is_big(input quat_code_t c);
    return ~c[0];
  endfunction
endpackage

// File: rtl/q2b1q_align_sync.sv
module q2b1q_align_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pulse_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = en_i & s2_q & ~s3_q;
endmodule

// File: rtl/q2b1q_pair_buf.sv
module q2b1q_pair_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic       take_i,
  output logic       full_o,
  output logic [1:0] pair_o
);
  logic [1:0] cnt_q;
  logic [1:0] data_q;
  logic       accept;

  assign ready_o = (cnt_q != 2'd2);
  assign full_o  = (cnt_q == 2'd2);
  assign accept  = valid_i & ready_o;
  assign pair_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      data_q <= 2'b00;
    end else if (take_i && full_o) begin
      cnt_q <= 2'd0;
    end else if (accept) begin
      cnt_q  <= cnt_q + 2'd1;
      data_q <= {data_q[0], bit_i};   // earlier bit ends in [1]
    end
  end
endmodule

// File: rtl/q2b1q_frame_ctr.sv
module q2b1q_frame_ctr #(
  parameter int FRAME_QUATS = 120,
  parameter int MF_FRAMES   = 8,
  localparam int POS_W = $clog2(FRAME_QUATS),
  localparam int FR_W  = $clog2(MF_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             restart_i,
  output logic [POS_W-1:0] pos_o,
  output logic [FR_W-1:0]  frame_o
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_QUATS - 1);
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(MF_FRAMES - 1);

  logic [POS_W-1:0] pos_q;
  logic [FR_W-1:0]  frame_q;

  assign pos_o   = restart_i ? '0 : pos_q;
  assign frame_o = restart_i ? '0 : frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else if (stb_i) begin
      if (pos_o == POS_LAST) begin
        pos_q   <= '0;
        frame_q <= (frame_o == FR_LAST) ? '0 : frame_o + 1'b1;
      end else begin
        pos_q   <= pos_o + 1'b1;
        frame_q <= frame_o;
      end
    end
  end
endmodule

// File: rtl/q2b1q_framer.sv
module q2b1q_framer #(
  parameter int                     FRAME_QUATS = 120,
  parameter int                     SYNC_QUATS  = 9,
  parameter int                     MF_FRAMES   = 8,
  // sync polarity, MSB sent first, 1 = +3, 0 = -3
  parameter logic [SYNC_QUATS-1:0]  SYNC_WORD   = 9'b110001011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_stb_i,
  input  logic       bit_i,
  input  logic       bit_valid_i,
  output logic       bit_ready_o,
  input  logic       align_mode_i,
  input  logic       align_i,
  output logic       quat_valid_o,
  output logic [1:0] quat_code_o,
  output logic       quat_neg_o,
  output logic       quat_big_o,
  output logic       frame_start_o,
  output logic       mframe_start_o,
  output logic       mframe_sq_o
);
  import q2b1q_pkg::*;

  localparam int POS_W  = $clog2(FRAME_QUATS);
  localparam int FR_W   = $clog2(MF_FRAMES);
  localparam int SYNC_W = $clog2(SYNC_QUATS);
  localparam logic [POS_W-1:0]  SYNC_LEN = POS_W'(SYNC_QUATS);
  localparam logic [SYNC_W-1:0] SYNC_TOP = SYNC_W'(SYNC_QUATS - 1);
  localparam logic [FR_W-1:0]   FR_HALF  = FR_W'(MF_FRAMES / 2);

  logic             al_edge, pend_q, restart;
  logic             buf_full, take;
  logic [1:0]       pair;
  logic [POS_W-1:0] pos;
  logic [FR_W-1:0]  frm;
  logic             in_sync, mf_first;
  logic [SYNC_W-1:0] sync_idx;
  quat_code_t       sync_code, pay_code, cur_code;

  q2b1q_align_sync u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (align_mode_i),
    .pulse_i (align_i),
    .edge_o  (al_edge)
  );

  q2b1q_pair_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_i),
    .valid_i (bit_valid_i),
    .ready_o (bit_ready_o),
    .take_i  (take),
    .full_o  (buf_full),
    .pair_o  (pair)
  );

  q2b1q_frame_ctr #(
    .FRAME_QUATS (FRAME_QUATS),
    .MF_FRAMES   (MF_FRAMES)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (sym_stb_i),
    .restart_i (restart),
    .pos_o     (pos),
    .frame_o   (frm)
  );

  // alignment request held until a strobe uses it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (sym_stb_i) pend_q <= 1'b0;
    else if (al_edge)   pend_q <= 1'b1;
  end

  assign restart  = sym_stb_i & (pend_q | al_edge);
  assign in_sync  = (pos < SYNC_LEN);
  assign mf_first = (frm == '0);
  assign sync_idx = SYNC_TOP - pos[SYNC_W-1:0];

  always_comb begin
    sync_code = SYNC_WORD[sync_idx] ? QC_POS3 : QC_NEG3;
    if (mf_first) sync_code = quat_negate(sync_code);
  end

  assign pay_code = buf_full ? quat_code_t'(pair) : QC_NEG3;
  assign take     = sym_stb_i & ~in_sync & buf_full;
  assign cur_code = in_sync ? sync_code : pay_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quat_valid_o   <= 1'b0;
      quat_code_o    <= 2'b00;
      quat_neg_o     <= 1'b0;
      quat_big_o     <= 1'b0;
      frame_start_o  <= 1'b0;
      mframe_start_o <= 1'b0;
      mframe_sq_o    <= 1'b0;
    end else begin
      quat_valid_o   <= sym_stb_i;
      frame_start_o  <= sym_stb_i & (pos == '0);
      mframe_start_o <= sym_stb_i & (pos == '0) & mf_first;
      if (sym_stb_i) begin
        quat_code_o <= cur_code;
        quat_neg_o  <= quat_is_neg(cur_code);
        quat_big_o  <= quat_is_big(cur_code);
        mframe_sq_o <= (frm < FR_HALF);
      end
    end
  end
endmodule

// File: rtl/q2b1q_framer_chk.sv
module q2b1q_framer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sym_stb_i,
  input logic       quat_valid_o,
  input logic [1:0] quat_code_o,
  input logic       frame_start_o,
  input logic       mframe_start_o,
  input logic       mframe_sq_o
);
  // R11
  stb_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_stb_i |=> quat_valid_o);
  // R11
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> !quat_valid_o);
  // R5
  mf_is_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mframe_start_o |-> frame_start_o);
  // R5
  mf_sync_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mframe_start_o |-> quat_code_o == 2'b00);
  // R4
  fr_sync_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !mframe_start_o) |-> quat_code_o == 2'b10);
  // R6
  sq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mframe_sq_o) |-> mframe_start_o);
endmodule

bind q2b1q_framer q2b1q_framer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sym_stb_i      (sym_stb_i),
  .quat_valid_o   (quat_valid_o),
  .quat_code_o    (quat_code_o),
  .frame_start_o  (frame_start_o),
  .mframe_start_o (mframe_start_o),
  .mframe_sq_o    (mframe_sq_o)
);

// File: tb/q2b1q_framer_test.sv
`timescale 1ns/1ps
module q2b1q_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, bit_d = 1'b0, bval = 1'b0, amode = 1'b0, al = 1'b0;
  logic bready, qvalid, qneg, qbig, fstart, mfstart, msq;
  logic [1:0] qcode;

  always #5 clk = ~clk;

  q2b1q_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_stb_i(stb), .bit_i(bit_d),
    .bit_valid_i(bval), .bit_ready_o(bready), .align_mode_i(amode),
    .align_i(al), .quat_valid_o(qvalid), .quat_code_o(qcode),
    .quat_neg_o(qneg), .quat_big_o(qbig), .frame_start_o(fstart),
    .mframe_start_o(mfstart), .mframe_sq_o(msq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int seed_k;
  int idx = 0, cons = 0;
  int m_pos = 0, m_fr = 0;
  logic m_sq = 1'b0;
  bit exp_on = 0;
  logic [1:0] e_code;
  logic e_neg, e_big, e_fs, e_mfs;
  string e_tag;
  bit al_armed = 0, al_prev = 0, ign_flag = 0;
  int al_age = 0;
  int cyc = 0;

  const int SYNC_LVL[9] = '{3, 3, -3, -3, -3, 3, -3, 3, 3};

  function automatic logic pat_bit(input int i);
    int unsigned h;
    h = (i * 32'd2654435761) + seed_k;
    return h[13];
  endfunction

  function automatic logic [1:0] lvl2code(input int l);
    case (l)
      3:       return 2'b10;
      1:       return 2'b11;
      -1:      return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int pair2lvl(input logic a, input logic b);
    if (a && !b) return 3;
    if (a && b)  return 1;
    if (!a && b) return -1;
    return -3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one clock: check prior edge results, drive, model
  task automatic cycle(input logic s, input logic v, input logic a);
    int lvl;
    bit rs;
    @(negedge clk);
    cyc++;
    chk("R2 ready", bready, ((idx - cons) < 2));
    if (exp_on) begin
      chk({e_tag, " R11 valid"}, qvalid, 1'b1);
      chk({e_tag, " code"}, qcode, e_code);
      chk("R1 sign", qneg, e_neg);
      chk("R1 mag", qbig, e_big);
      chk({e_tag, " R3 frame_start"}, fstart, e_fs);
      chk({e_tag, " R5 mframe_start"}, mfstart, e_mfs);
      chk("R6 square", msq, m_sq);
    end else begin
      chk("R11 idle valid", qvalid, 1'b0);
      chk("R11 idle fs", fstart, 1'b0);
      chk("R11 idle mfs", mfstart, 1'b0);
      chk("R6 square hold", msq, m_sq);
    end
    exp_on = 0;
    stb = s; bval = v; al = a; bit_d = pat_bit(idx);
    if (a && !al_prev) begin
      if (amode) begin al_armed = 1; al_age = 0; end
      else ign_flag = 1;
    end
    al_prev = a;
    if (s) begin
      rs = al_armed && (al_age >= 2);
      if (rs) begin m_pos = 0; m_fr = 0; al_armed = 0; end
      e_tag = rs ? "R7" : (ign_flag ? "R8" : "");
      ign_flag = 0;
      if (m_pos < 9) begin
        lvl = (m_fr == 0) ? -SYNC_LVL[m_pos] : SYNC_LVL[m_pos];
        e_tag = {e_tag, (m_fr == 0) ? " R5 sync" : " R4 sync"};
      end else if ((idx - cons) >= 2) begin
        lvl = pair2lvl(pat_bit(cons), pat_bit(cons + 1));
        cons += 2;
        e_tag = {e_tag, " R1 payload"};
      end else begin
        lvl = -3;
        e_tag = {e_tag, " R9 underrun"};
      end
      e_code = lvl2code(lvl);
      e_neg = (lvl < 0);
      e_big = (lvl == 3) || (lvl == -3);
      e_fs = (m_pos == 0);
      e_mfs = (m_pos == 0) && (m_fr == 0);
      m_sq = (m_fr < 4);
      exp_on = 1;
      if (m_pos == 119) begin m_pos = 0; m_fr = (m_fr + 1) % 8; end
      else m_pos++;
    end
    if (v && bready) idx++;
    if (al_armed) al_age++;
  endtask

  task automatic run_random(input int n_stb, input int v_pct, input int al_pct);
    for (int k = 0; k < n_stb; k++) begin
      int gap = 3 + ($urandom % 4);
      bit do_al = (($urandom % 1000) < al_pct);
      for (int g = 0; g < gap; g++)
        cycle(1'b0, (($urandom % 100) < v_pct), do_al && (g < 2));
      cycle(1'b1, (($urandom % 100) < v_pct), 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    seed_k = $urandom;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", qvalid, 1'b0);
    chk("R10 fs", fstart, 1'b0);
    chk("R10 mfs", mfstart, 1'b0);
    chk("R10 square", msq, 1'b0);
    chk("R10 ready", bready, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b0);
    // R10 first symbol is multiframe start; full buffer stream
    run_random(1000, 100, 0);
    // R8 alignment ignored when mode off
    run_random(300, 95, 20);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 1'b0);
    amode = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0);
    // R7 strobe one cycle too early: no restart yet, next strobe restarts
    run_random(40, 100, 0);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 1'b0);
    run_random(50, 100, 0);
    // R7 strobe on the first cycle the synchronized edge is seen
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    run_random(30, 100, 0);
    // R9 underrun: valid held low across payload strobes
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b0);
      cycle(1'b1, 1'b0, 1'b0);
    end
    // mixed random with alignment pulses and valid gaps
    run_random(2500, 85, 8);
    run_random(200, 100, 0);
    cycle(1'b0, 1'b1, 1'b0);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end
endmodule